// File: doc/BRIEF.md
# String Operation Repeat Engine

This block carries out one repeated string operation against a byte-addressed memory. It handles five kinds of element operation: copy, compare, scan, load and store. An element is one, two or four bytes. A caller sets the operation, element size, repeat prefix, source and destination pointers, element count, accumulator, direction flag and starting zero and carry flags, then pulses `start`. The engine walks the elements one at a time.

For each element the engine issues reads and writes through a single request/acknowledge memory port. It then steps whichever pointers the operation uses and, under a prefix, decrements the count. After every element it decides from the prefix whether to go on. It may stop on the count alone, or on the count combined with the zero flag or the carry flag.

When the engine stops, it raises `done` for one cycle. At that point the updated pointers, count, accumulator and flags are valid on its outputs and stay there until the next start.

Top module: `strop_repeat_engine`

## Requirements
- R1: `op_i` codes are 0 copy, 1 compare, 2 scan, 3 load and 4 store. `start` is taken only while `busy` is low. `busy` is high from the cycle after `start` until `done` falls, and `mem_req` is never high while `busy` is low.
- R2: `size_i` codes are 0 byte, 1 word and 2 doubleword, and 3 acts as doubleword. An element occupies the low bytes of `mem_rdata` and `mem_wdata`, and bytes above the element in `mem_rdata` are ignored. `mem_size` carries the size code, and the pointer step is 1, 2 or 4.
- R3: With `df_i`=0 each pointer in use moves up by the step after an element, and with `df_i`=1 it moves down. Copy and compare move both pointers, scan and store move only the destination, and load moves only the source.
- R4: With `rep_i`=0 exactly one element is processed whatever the count, and `cnt_o` equals `cnt_i`.
- R5: With `rep_i`=1 elements repeat until the count reaches zero. The count drops by one per completed element.
- R6: With `rep_i`=2 the engine goes on only while the count is nonzero and ZF is 1 after the element. With `rep_i`=3 it goes on only while the count is nonzero and ZF is 0.
- R7: With `rep_i`=4 the engine goes on only while the count is nonzero and CF is 1. With `rep_i`=5 it goes on only while the count is nonzero and CF is 0. Under every prefix the flags a non-comparing operation sees are the starting ones.
- R8: With any prefix and a zero count, no memory request is made, and `done` is high in the second cycle after `start` is taken.
- R9: Compare subtracts the destination element from the source element, and scan subtracts it from the accumulator's low element. ZF is set on equality. CF is set on a borrow, meaning the first operand is smaller unsigned. Copy, load and store leave both flags unchanged.
- R10: Load replaces the accumulator's low element bytes and keeps its upper bits. Store writes the accumulator's low element with zero upper bytes. Copy reads the source and writes that same value to the destination.
- R11: Each request holds `mem_addr`, `mem_we`, `mem_size` and `mem_wdata` stable until `mem_ack`. Compare reads the source before the destination, and copy reads before it writes.
- R12: `done` lasts exactly one cycle. When `done` is high, the output pointers, count, accumulator and flags hold the final values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation with the inputs below |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Element size code |
| rep_i | input | 3 | Repeat prefix code |
| df_i | input | 1 | Direction: 0 up, 1 down |
| zf_i | input | 1 | Starting zero flag |
| cf_i | input | 1 | Starting carry flag |
| src_i | input | AW | Starting source pointer |
| dst_i | input | AW | Starting destination pointer |
| cnt_i | input | CW | Starting element count |
| acc_i | input | 32 | Starting accumulator |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request byte address |
| mem_size | output | 2 | Request size code |
| mem_wdata | output | 32 | Write data, element in low bytes |
| mem_ack | input | 1 | Request completes at this edge |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| src_o | output | AW | Current source pointer |
| dst_o | output | AW | Current destination pointer |
| cnt_o | output | CW | Current count |
| acc_o | output | 32 | Current accumulator |
| zf_o | output | 1 | Current zero flag |
| cf_o | output | 1 | Current carry flag |

## Verification
`start` is taken at one edge and the prefix and count are tested at the next, so a zero-count run shows `done` at the second sampling point after `start`. The bench counts these cycles and checks that exact figure. Memory requests appear one cycle after the previous acknowledge or test edge, and each is compared on the acknowledge cycle against a behavioural model's queue of expected transactions. The acknowledge is delayed by zero to two cycles, and every cycle a request waits is checked for stability. Pointer, count, accumulator and flag results are due at the `done` pulse, one cycle after the last element's step. They are compared there, and `done` is checked low again one cycle later.

// File: rtl/strop_pkg.sv
package strop_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    OP_MOVE  = 3'd0,
    OP_CMP   = 3'd1,
    OP_SCAN  = 3'd2,
    OP_LOAD  = 3'd3,
    OP_STORE = 3'd4
  } strop_op_e;

  typedef enum logic [2:0] {
    RP_NONE = 3'd0,
    RP_ALL  = 3'd1,
    RP_EQ   = 3'd2,
    RP_NE   = 3'd3,
    RP_CY   = 3'd4,
    RP_NC   = 3'd5
  } strop_rep_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_RSRC, ST_RDST, ST_WDST, ST_STEP, ST_FIN
  } strop_st_e;

  function automatic logic [2:0] elem_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] elem_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00ff;
      2'd1:    return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  function automatic logic uses_src(input strop_op_e op);
    return (op == OP_MOVE) || (op == OP_CMP) || (op == OP_LOAD);
  endfunction

  function automatic logic uses_dst(input strop_op_e op);
    return (op == OP_MOVE) || (op == OP_CMP) || (op == OP_SCAN) || (op == OP_STORE);
  endfunction

  function automatic logic rep_continue(input strop_rep_e rep, input logic any_left,
                                        input logic zf, input logic cf);
    case (rep)
      RP_ALL:  return any_left;
      RP_EQ:   return any_left && zf;
      RP_NE:   return any_left && !zf;
      RP_CY:   return any_left && cf;
      RP_NC:   return any_left && !cf;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/strop_flag_unit.sv
module strop_flag_unit
  import strop_pkg::*;
(
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  input  logic [1:0]        sz,
  output logic              zf,
  output logic              cf
);
  function automatic logic [DATA_W:0] masked_sub(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b,
                                                 input logic [DATA_W-1:0] m);
    return {1'b0, a & m} - {1'b0, b & m};
  endfunction

  logic [DATA_W:0] diff;

  always_comb begin
    diff = masked_sub(lhs, rhs, elem_mask(sz));
    zf   = (diff[DATA_W-1:0] == '0);
    cf   = diff[DATA_W];
  end
endmodule

// File: rtl/strop_ptr_step.sv
module strop_ptr_step
  import strop_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic [1:0]    sz,
  input  logic          down,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] step;

  always_comb begin
    step = AW'(elem_bytes(sz));
    nxt  = down ? (ptr - step) : (ptr + step);
  end
endmodule

// File: rtl/strop_repeat_engine.sv
module strop_repeat_engine
  import strop_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [2:0]        rep_i,
  input  logic              df_i,
  input  logic              zf_i,
  input  logic              cf_i,
  input  logic [AW-1:0]     src_i,
  input  logic [AW-1:0]     dst_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [AW-1:0]     src_o,
  output logic [AW-1:0]     dst_o,
  output logic [CW-1:0]     cnt_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              zf_o,
  output logic              cf_o
);
  localparam int NPTR = 2;

  strop_st_e         st;
  strop_op_e         op_q;
  strop_rep_e        rep_q;
  logic [1:0]        sz_q;
  logic              df_q, zf_q, cf_q;
  logic [AW-1:0]     src_q, dst_q;
  logic [CW-1:0]     cnt_q, cnt_dec;
  logic [DATA_W-1:0] acc_q, tmp_q, mask, rd_elem, cmp_lhs;
  logic              cmp_zf, cmp_cf;

  // Named events for the checker
  logic elem_step, zero_skip;

  logic [AW-1:0] ptr_cur [NPTR];
  logic [AW-1:0] ptr_nxt [NPTR];

  assign ptr_cur[0] = src_q;
  assign ptr_cur[1] = dst_q;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    strop_ptr_step #(.AW(AW)) u_step (
      .ptr  (ptr_cur[g]),
      .sz   (sz_q),
      .down (df_q),
      .nxt  (ptr_nxt[g])
    );
  end

  always_comb begin
    mask    = elem_mask(sz_q);
    rd_elem = mem_rdata & mask;
    cmp_lhs = (op_q == OP_CMP) ? tmp_q : acc_q;
    cnt_dec = cnt_q - CW'(1);
  end

  strop_flag_unit u_flags (
    .lhs (cmp_lhs),
    .rhs (mem_rdata),
    .sz  (sz_q),
    .zf  (cmp_zf),
    .cf  (cmp_cf)
  );

  assign elem_step = (st == ST_STEP);
  assign zero_skip = (st == ST_CHECK) && (rep_q != RP_NONE) && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      op_q  <= OP_MOVE;
      rep_q <= RP_NONE;
      sz_q  <= '0;
      df_q  <= 1'b0;
      zf_q  <= 1'b0;
      cf_q  <= 1'b0;
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      acc_q <= '0;
      tmp_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          op_q  <= strop_op_e'(op_i);
          rep_q <= strop_rep_e'(rep_i);
          sz_q  <= size_i;
          df_q  <= df_i;
          zf_q  <= zf_i;
          cf_q  <= cf_i;
          src_q <= src_i;
          dst_q <= dst_i;
          cnt_q <= cnt_i;
          acc_q <= acc_i;
          st    <= ST_CHECK;
        end
        ST_CHECK: begin
          if (zero_skip) st <= ST_FIN;
          else begin
            case (op_q)
              OP_MOVE, OP_CMP, OP_LOAD: st <= ST_RSRC;
              OP_SCAN:                  st <= ST_RDST;
              OP_STORE:                 st <= ST_WDST;
              default:                  st <= ST_FIN;
            endcase
          end
        end
        ST_RSRC: if (mem_ack) begin
          tmp_q <= rd_elem;
          if (op_q == OP_LOAD) acc_q <= (acc_q & ~mask) | rd_elem;
          if (op_q == OP_MOVE)     st <= ST_WDST;
          else if (op_q == OP_CMP) st <= ST_RDST;
          else                     st <= ST_STEP;
        end
        ST_RDST: if (mem_ack) begin
          zf_q <= cmp_zf;
          cf_q <= cmp_cf;
          st   <= ST_STEP;
        end
        ST_WDST: if (mem_ack) st <= ST_STEP;
        ST_STEP: begin
          if (uses_src(op_q)) src_q <= ptr_nxt[0];
          if (uses_dst(op_q)) dst_q <= ptr_nxt[1];
          if (rep_q != RP_NONE) cnt_q <= cnt_dec;
          if (rep_q != RP_NONE && rep_continue(rep_q, cnt_dec != '0, zf_q, cf_q))
            st <= ST_CHECK;
          else
            st <= ST_FIN;
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = (st == ST_RSRC) || (st == ST_RDST) || (st == ST_WDST);
    mem_we    = (st == ST_WDST);
    mem_addr  = (st == ST_RSRC) ? src_q : dst_q;
    mem_size  = sz_q;
    mem_wdata = (st != ST_WDST) ? '0 :
                (op_q == OP_MOVE) ? tmp_q : (acc_q & mask);
  end

  assign busy  = (st != ST_IDLE);
  assign done  = (st == ST_FIN);
  assign src_o = src_q;
  assign dst_o = dst_q;
  assign cnt_o = cnt_q;
  assign acc_o = acc_q;
  assign zf_o  = zf_q;
  assign cf_o  = cf_q;
endmodule

// File: rtl/strop_repeat_engine_chk.sv
module strop_repeat_engine_chk
  import strop_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [1:0]        mem_size,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              busy,
  input logic              done,
  input logic [AW-1:0]     src_o,
  input logic [AW-1:0]     dst_o,
  input logic [CW-1:0]     cnt_o,
  input logic              elem_step,
  input logic              zero_skip,
  input strop_op_e         op_q,
  input strop_rep_e        rep_q,
  input logic [1:0]        sz_q,
  input logic              df_q
);
  logic [AW-1:0] stp;
  logic          src_moves, dst_moves;

  always_comb begin
    stp = (sz_q == 2'd0) ? AW'(1) : (sz_q == 2'd1) ? AW'(2) : AW'(4);
    src_moves = (op_q == OP_MOVE) || (op_q == OP_CMP) || (op_q == OP_LOAD);
    dst_moves = (op_q != OP_LOAD);
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_size) && $stable(mem_wdata));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  a_r8_zero_skip: assert property (@(posedge clk) disable iff (!rst_n)
    zero_skip |=> done && !mem_req);

  a_r5_cnt_dec: assert property (@(posedge clk) disable iff (!rst_n)
    elem_step && rep_q != RP_NONE |=> cnt_o == $past(cnt_o) - CW'(1));

  a_r4_single: assert property (@(posedge clk) disable iff (!rst_n)
    elem_step && rep_q == RP_NONE |=> $stable(cnt_o) && done);

  a_r3_src_step: assert property (@(posedge clk) disable iff (!rst_n)
    elem_step && src_moves |=>
      src_o == ($past(df_q) ? $past(src_o) - $past(stp) : $past(src_o) + $past(stp)));

  a_r3_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
    elem_step && dst_moves |=>
      dst_o == ($past(df_q) ? $past(dst_o) - $past(stp) : $past(dst_o) + $past(stp)));

  a_r3_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
    elem_step && !src_moves |=> $stable(src_o));
endmodule

bind strop_repeat_engine strop_repeat_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_size  (mem_size),
  .mem_wdata (mem_wdata),
  .busy      (busy),
  .done      (done),
  .src_o     (src_o),
  .dst_o     (dst_o),
  .cnt_o     (cnt_o),
  .elem_step (elem_step),
  .zero_skip (zero_skip),
  .op_q      (op_q),
  .rep_q     (rep_q),
  .sz_q      (sz_q),
  .df_q      (df_q)
);

// File: tb/tb_strop_repeat_engine.sv
module tb_strop_repeat_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    op_i = '0;
  logic [1:0]    size_i = '0;
  logic [2:0]    rep_i = '0;
  logic          df_i = 1'b0, zf_i = 1'b0, cf_i = 1'b0;
  logic [AW-1:0] src_i = '0, dst_i = '0;
  logic [CW-1:0] cnt_i = '0;
  logic [31:0]   acc_i = '0;
  logic          mem_req, mem_we, busy, done, zf_o, cf_o;
  logic [AW-1:0] mem_addr, src_o, dst_o;
  logic [1:0]    mem_size;
  logic [31:0]   mem_wdata, acc_o;
  logic [CW-1:0] cnt_o;
  logic          mem_ack = 1'b0;
  logic [31:0]   mem_rdata = '0;

  strop_repeat_engine #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_i(op_i), .size_i(size_i),
    .rep_i(rep_i), .df_i(df_i), .zf_i(zf_i), .cf_i(cf_i), .src_i(src_i),
    .dst_i(dst_i), .cnt_i(cnt_i), .acc_i(acc_i), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o),
    .acc_o(acc_o), .zf_o(zf_o), .cf_o(cf_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;

  logic [7:0]  mem [256];
  logic [7:0]  mm  [256];
  bit          eq_we   [$];
  logic [15:0] eq_addr [$];
  logic [31:0] eq_dat  [$];
  logic [15:0] e_src, e_dst, e_cnt;
  logic [31:0] e_acc;
  bit          e_zf, e_cf;
  int          cur_bytes = 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mm_rd(input logic [15:0] a, input int n);
    logic [31:0] v = '0;
    for (int k = 0; k < n; k++) v[8*k +: 8] = mm[8'(a + 16'(k))];
    return v;
  endfunction

  task automatic mm_wr(input logic [15:0] a, input int n, input logic [31:0] v);
    for (int k = 0; k < n; k++) mm[8'(a + 16'(k))] = v[8*k +: 8];
  endtask

  task automatic push(input bit w, input logic [15:0] a, input logic [31:0] v);
    eq_we.push_back(w); eq_addr.push_back(a); eq_dat.push_back(v);
  endtask

  // Behavioural reference: walks the whole operation, queueing transactions
  task automatic model(input int op, input int sz, input int rep,
                       input logic [15:0] s0, input logic [15:0] d0,
                       input logic [15:0] c0, input logic [31:0] a0,
                       input bit df, input bit z0, input bit f0);
    int n;
    logic [31:0] m, x, y;
    logic [15:0] s, d, c;
    logic [31:0] a;
    bit z, f, go;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    m = (n == 1) ? 32'hff : (n == 2) ? 32'hffff : 32'hffff_ffff;
    s = s0; d = d0; c = c0; a = a0; z = z0; f = f0;
    for (int i = 0; i < 256; i++) mm[i] = mem[i];
    eq_we.delete(); eq_addr.delete(); eq_dat.delete();
    go = !(rep != 0 && c == 0);
    while (go) begin
      case (op)
        0: begin x = mm_rd(s, n); push(0, s, 0); push(1, d, x); mm_wr(d, n, x); end
        1: begin x = mm_rd(s, n); y = mm_rd(d, n); push(0, s, 0); push(0, d, 0);
                 z = (x == y); f = (x < y); end
        2: begin y = mm_rd(d, n); push(0, d, 0); z = ((a & m) == y); f = ((a & m) < y); end
        3: begin x = mm_rd(s, n); push(0, s, 0); a = (a & ~m) | x; end
        default: begin push(1, d, a & m); mm_wr(d, n, a & m); end
      endcase
      if (op == 0 || op == 1 || op == 3) s = df ? s - 16'(n) : s + 16'(n);
      if (op != 3) d = df ? d - 16'(n) : d + 16'(n);
      if (rep == 0) go = 0;
      else begin
        c = c - 1;
        case (rep)
          1: go = (c != 0);
          2: go = (c != 0) && z;
          3: go = (c != 0) && !z;
          4: go = (c != 0) && f;
          5: go = (c != 0) && !f;
          default: go = 0;
        endcase
      end
    end
    e_src = s; e_dst = d; e_cnt = c; e_acc = a; e_zf = z; e_cf = f;
  endtask

  // Memory responder with varying latency; checks every waiting cycle
  initial begin
    int lat = 0, waited = 0;
    logic [15:0] h_addr = '0;
    logic [31:0] h_wd = '0;
    bit h_we = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        waited = 0;
      end else if (mem_req) begin
        if (waited > 0)
          chk(mem_addr == h_addr && mem_we == h_we && mem_wdata == h_wd,
              "R11 hold", mem_addr, h_addr);
        h_addr = mem_addr; h_we = mem_we; h_wd = mem_wdata;
        if (waited < lat) waited++;
        else begin
          lat = (lat + 1) % 3;
          chk(32'(mem_size) == 32'(cur_bytes == 1 ? 0 : cur_bytes == 2 ? 1 : 2) ||
              (cur_bytes == 4 && mem_size == 2'd3), "R2 size", mem_size, cur_bytes);
          if (eq_we.size() == 0) chk(0, "R11 extra request", mem_addr, 0);
          else begin
            bit w;
            logic [15:0] a;
            logic [31:0] v;
            w = eq_we.pop_front(); a = eq_addr.pop_front(); v = eq_dat.pop_front();
            chk(mem_we == w, "R11 order", mem_we, w);
            chk(mem_addr == a, "R3 address", mem_addr, a);
            if (mem_we) begin
              chk(mem_wdata == v, "R10 wdata", mem_wdata, v);
              for (int k = 0; k < cur_bytes; k++) mem[8'(mem_addr + 16'(k))] = mem_wdata[8*k +: 8];
            end else begin
              for (int k = 0; k < 4; k++) mem_rdata[8*k +: 8] = mem[8'(mem_addr + 16'(k))];
            end
          end
          mem_ack = 1'b1;
        end
      end
    end
  end

  task automatic run(input string tag, input int op, input int sz, input int rep,
                     input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                     input logic [31:0] a, input bit df, input bit z, input bit f,
                     input int exp_cyc);
    int cyc;
    model(op, sz, rep, s, d, c, a, df, z, f);
    cur_bytes = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    @(negedge clk);
    op_i = 3'(op); size_i = 2'(sz); rep_i = 3'(rep); src_i = s; dst_i = d;
    cnt_i = c; acc_i = a; df_i = df; zf_i = z; cf_i = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1 busy", busy, 1);
    cyc = 1;
    while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
    if (!done) chk(0, {tag, " watchdog: done never seen"}, 0, 1);
    if (exp_cyc > 0) chk(cyc == exp_cyc, {tag, " done latency"}, cyc, exp_cyc);
    chk(src_o == e_src, "R3 src", src_o, e_src);
    chk(dst_o == e_dst, "R3 dst", dst_o, e_dst);
    chk(cnt_o == e_cnt, {tag, " count"}, cnt_o, e_cnt);
    chk(acc_o == e_acc, "R10 acc", acc_o, e_acc);
    chk(zf_o == e_zf, "R9 zf", zf_o, e_zf);
    chk(cf_o == e_cf, "R9 cf", cf_o, e_cf);
    chk(eq_we.size() == 0, {tag, " missing transactions"}, eq_we.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, "R12 pulse", done, 0);
    chk(busy == 1'b0, "R1 idle", busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "R12 watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && mem_req == 0, "R1 reset", {busy, done, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run("R5 copy byte up",       0, 0, 1, 16'h10, 16'h40, 16'd4, 0, 0, 0, 0, 0);
    run("R5 copy word down",     0, 1, 1, 16'h30, 16'h80, 16'd3, 0, 1, 0, 0, 0);
    run("R10 store dword",       4, 2, 1, 16'h00, 16'hA0, 16'd2, 32'hDEADBEEF, 0, 1, 1, 0);
    run("R4 load no prefix",     3, 0, 0, 16'h21, 16'h00, 16'd5, 32'h11223344, 0, 0, 0, 0);
    run("R4 single with zero count", 4, 1, 0, 16'h00, 16'hC0, 16'd0, 32'hA5A55A5A, 0, 0, 0, 0);
    mem[8'h62] = 8'h77;
    run("R6 scan until equal",   2, 0, 3, 16'h00, 16'h60, 16'd10, 32'h0000_0077, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) mem[8'h70 + i] = 8'h55;
    mem[8'h73] = 8'h54;
    run("R6 scan while equal",   2, 0, 2, 16'h00, 16'h70, 16'd8, 32'hFFFF_FF55, 0, 1, 0, 0);
    for (int i = 0; i < 8; i++) begin mem[8'h90 + i] = 8'(i); mem[8'hB0 + i] = 8'(i); end
    mem[8'h95] = 8'h03; mem[8'hB5] = 8'h09;
    run("R9 compare word equal", 1, 1, 2, 16'h90, 16'hB0, 16'd4, 0, 0, 1, 0, 0);
    run("R7 compare carry set",  1, 0, 4, 16'hB0, 16'h90, 16'd6, 0, 0, 0, 1, 0);
    run("R7 compare carry clear", 1, 0, 5, 16'h90, 16'hB0, 16'd6, 0, 0, 0, 0, 0);
    run("R8 zero count",         0, 0, 1, 16'h10, 16'h40, 16'd0, 0, 0, 0, 0, 2);
    run("R7 copy zf gate",       0, 0, 2, 16'h10, 16'h50, 16'd5, 0, 0, 0, 0, 0);
    run("R2 size code three",    3, 3, 1, 16'h08, 16'h00, 16'd2, 32'h0, 0, 0, 0, 0);
    run("R11 compare dword down", 1, 2, 3, 16'h9C, 16'hBC, 16'd3, 0, 1, 1, 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule